// File: doc/BRIEF.md
# Transactional Line Buffer

This block is a small fully associative store that sits next to a processor's data cache. It holds only the lines that the current transaction has touched, one data word per line. The core drives six operations into it: a transactional read, a transactional read that claims the line for exclusive use, a transactional write, commit, abort and validate. Writes change only the buffered copy. Other agents see them only after a successful commit. At that point the block walks its array and presents every written line on a write-back port. A transaction starts on its first read or write.

The block also watches a snoop port that carries read and exclusive requests from other processors. A snoop that hits a held line is checked in the same cycle. The block refuses it with a NACK if the request would break isolation, and its own transaction stays alive. A read that misses the buffer fetches its word from the memory port. If another agent refuses that fetch, or if a new line is needed while every slot is full, the transaction is marked invalid. In the full-buffer case an overflow output also tells software to take over.

Top module: `txn_line_buffer`

## Requirements
- R1: After reset, op_ready is 1, and rsp_valid, snp_rsp_valid, wb_valid and overflow are 0. A validate issued straight after reset returns rsp_ok = 0.
- R2: Every accepted operation (op_valid and op_ready high at a clock edge) produces rsp_valid high exactly one cycle later, and at no other time. The op_code values are: 0 read, 1 exclusive read, 2 write, 3 commit, 4 abort, 5 validate.
- R3: A read or exclusive read that misses the buffer drives op_addr on mem_raddr and allocates a line holding mem_rdata. It returns that word with rsp_ok = 1. Later reads of the same address return the buffered word even if memory has since changed.
- R4: A write changes only the buffered line. Later reads of that address return the written value, and wb_valid stays 0 until a commit succeeds.
- R5: A commit while the transaction is valid returns rsp_ok = 1. op_ready then drops for exactly ENTRIES cycles, and each written line appears once on wb_valid/wb_addr/wb_data. Afterwards the buffer is empty and validate returns 0.
- R6: An abort (rsp_ok = 1) or a commit on an invalid transaction (rsp_ok = 0) discards every line with no write-back and no drop of op_ready. Afterwards validate returns 0 and the overflow output is 0.
- R7: Validate reports the valid flag in rsp_ok and changes no state.
- R8: One cycle after snp_valid, snp_rsp_valid is 1. snp_nack is 1 exactly when the snooped address is held and either snp_excl is 1 or the line was written or read exclusively. A plain read snoop of a line that was only read, or of an address not held, gets no NACK.
- R9: Refusing a snoop leaves the own transaction valid, and it can still commit.
- R10: A read or write that needs a new line while all ENTRIES lines are held sets overflow, which stays set until commit or abort. It also clears the valid flag, and a read returns the poison word with rsp_ok = 0.
- R11: If mem_nack is 1 during a read miss, no line is allocated, the valid flag clears, and the poison word is returned with rsp_ok = 0.
- R12: Once the transaction is invalid, reads (hits included) return the poison word with rsp_ok = 0, and writes neither allocate nor mark a line written. This lasts until the next commit or abort. In the poison word every odd bit position is 1 and every even one is 0 (0xAAAA for 16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Core operation request |
| op_code | input | 3 | Operation code (see R2) |
| op_addr | input | ADDR_W | Line address of the operation |
| op_wdata | input | DATA_W | Write data |
| op_ready | output | 1 | Operation can be accepted |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Success or valid-flag result |
| rsp_data | output | DATA_W | Read result |
| mem_raddr | output | ADDR_W | Fill address |
| mem_rdata | input | DATA_W | Fill data, same cycle |
| mem_nack | input | 1 | Fill refused by another agent |
| snp_valid | input | 1 | Remote request strobe |
| snp_excl | input | 1 | Remote request wants exclusive ownership |
| snp_addr | input | ADDR_W | Remote request line address |
| snp_rsp_valid | output | 1 | Snoop reply strobe |
| snp_nack | output | 1 | Remote request refused |
| wb_valid | output | 1 | Committed line being written back |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |
| overflow | output | 1 | Transaction exceeded buffer capacity |

## Verification
The assertions assume that the memory port answers in the same cycle and that op_code is only ever one of the six defined values. They also assume that op_valid is raised only while op_ready is high, so every operation lands outside the commit drain. The bench holds to this by driving one operation at a time, changing inputs on the falling edge only, and waiting out the whole drain after each successful commit. It never offers a snoop in the same cycle as a core operation that could change the snooped line.

// File: rtl/txb_pkg.sv
package txb_pkg;

    typedef enum logic [2:0] {
        OP_LD       = 3'd0,
        OP_LDX      = 3'd1,
        OP_ST       = 3'd2,
        OP_COMMIT   = 3'd3,
        OP_ABORT    = 3'd4,
        OP_VALIDATE = 3'd5
    } txb_op_e;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } txb_state_e;

    typedef struct packed {
        logic vld;
        logic dirty;
        logic excl;
    } txb_meta_t;

    // Poison word: odd bit positions set, even positions clear.
    function automatic logic [63:0] txb_poison();
        logic [63:0] w;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            w[2*i+1] = 1'b1;
        end
        return w;
    endfunction

    // A remote request must be refused when it would break isolation.
    function automatic logic txb_conflicts(input logic want_excl, input txb_meta_t m);
        return m.vld && (want_excl || m.dirty || m.excl);
    endfunction

endpackage

// File: rtl/txb_match.sv
module txb_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] tags [ENTRIES],
    input  logic [ENTRIES-1:0] live,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = live[g] && (tags[g] == addr);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    // R3: the allocator never places one address in two slots
    a_r3_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(eq));

endmodule

// File: rtl/txb_alloc.sv
module txb_alloc #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0] used,
    output logic               any_free,
    output logic [IDX_W-1:0]   pick
);
    always_comb begin
        any_free = ~&used;
        pick     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!used[i]) pick = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txb_flags.sv
module txb_flags (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic kill,
    input  logic ovf_set,
    input  logic clr,
    output logic active,
    output logic valid,
    output logic ovf
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active <= 1'b0;
            valid  <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (start) active <= 1'b1;
            valid <= (valid || (start && !active)) && !kill && !ovf_set;
            if (ovf_set) ovf <= 1'b1;
        end
    end

    a_r12_valid_needs_active: assert property (@(posedge clk) disable iff (rst) valid |-> active);
    a_r10_ovf_kills_valid:    assert property (@(posedge clk) disable iff (rst) ovf |-> !valid);

endmodule

// File: rtl/txn_line_buffer.sv
module txn_line_buffer
    import txb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_ready,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_nack,
    input  logic              snp_valid,
    input  logic              snp_excl,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_rsp_valid,
    output logic              snp_nack,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              overflow
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [DATA_W-1:0] POISON = DATA_W'(txb_poison());

    txb_op_e     op;
    txb_state_e  state;
    logic [IDX_W-1:0]  wb_idx;
    txb_meta_t   meta      [ENTRIES];
    logic [ADDR_W-1:0] line_tag  [ENTRIES];
    logic [DATA_W-1:0] line_data [ENTRIES];
    logic [ENTRIES-1:0] used;

    logic c_hit, s_hit, free_any;
    logic [IDX_W-1:0] c_idx, s_idx, free_idx;
    logic flag_active, flag_valid;

    logic op_go, is_ld, is_st, acc, live_txn, want_new;
    logic ovf_evt, fill_refused, do_alloc, do_hit;
    logic commit_ok, discard, drain_last, wipe, s_conf;
    logic nxt_ok;
    logic [DATA_W-1:0] nxt_data;

    assign op = txb_op_e'(op_code);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_used
        assign used[g] = meta[g].vld;
    end

    txb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_core_match (
        .clk(clk), .rst(rst), .tags(line_tag), .live(used),
        .addr(op_addr), .hit(c_hit), .idx(c_idx)
    );

    txb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop_match (
        .clk(clk), .rst(rst), .tags(line_tag), .live(used),
        .addr(snp_addr), .hit(s_hit), .idx(s_idx)
    );

    txb_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .used(used), .any_free(free_any), .pick(free_idx)
    );

    txb_flags u_flags (
        .clk(clk), .rst(rst), .start(acc), .kill(fill_refused),
        .ovf_set(ovf_evt), .clr(wipe),
        .active(flag_active), .valid(flag_valid), .ovf(overflow)
    );

    // Operation decode and allocation decisions
    always_comb begin
        op_go        = op_valid && op_ready;
        is_ld        = op_go && (op == OP_LD || op == OP_LDX);
        is_st        = op_go && (op == OP_ST);
        acc          = is_ld || is_st;
        live_txn     = flag_valid || !flag_active;
        want_new     = acc && live_txn && !c_hit;
        ovf_evt      = want_new && !free_any;
        fill_refused = want_new && free_any && is_ld && mem_nack;
        do_alloc     = want_new && free_any && !fill_refused;
        do_hit       = acc && live_txn && c_hit;
        commit_ok    = op_go && (op == OP_COMMIT) && flag_valid;
        discard      = op_go && ((op == OP_ABORT) || ((op == OP_COMMIT) && !flag_valid));
        drain_last   = (state == ST_DRAIN) && (wb_idx == IDX_W'(ENTRIES - 1));
        wipe         = discard || drain_last;
        s_conf       = s_hit && txb_conflicts(snp_excl, meta[s_idx]);
    end

    // Response contents
    always_comb begin
        nxt_ok   = 1'b0;
        nxt_data = '0;
        case (op)
            OP_LD, OP_LDX: begin
                nxt_ok   = do_hit || do_alloc;
                nxt_data = do_hit ? line_data[c_idx] : (do_alloc ? mem_rdata : POISON);
            end
            OP_ST:       nxt_ok = do_hit || do_alloc;
            OP_COMMIT:   nxt_ok = flag_valid;
            OP_ABORT:    nxt_ok = 1'b1;
            OP_VALIDATE: nxt_ok = flag_valid;
            default:     nxt_ok = 1'b0;
        endcase
    end

    assign op_ready  = (state == ST_RUN);
    assign mem_raddr = op_addr;
    assign wb_valid  = (state == ST_DRAIN) && meta[wb_idx].dirty;
    assign wb_addr   = line_tag[wb_idx];
    assign wb_data   = line_data[wb_idx];

    // Control state and per-line metadata
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) meta[i] <= '0;
            state  <= ST_RUN;
            wb_idx <= '0;
        end else begin
            if (commit_ok) begin
                state  <= ST_DRAIN;
                wb_idx <= '0;
            end else if (state == ST_DRAIN) begin
                wb_idx <= wb_idx + 1'b1;
                if (drain_last) state <= ST_RUN;
            end
            if (wipe) begin
                for (int i = 0; i < ENTRIES; i++) meta[i] <= '0;
            end else if (do_alloc) begin
                meta[free_idx] <= '{vld: 1'b1, dirty: is_st, excl: (op == OP_LDX)};
            end else if (do_hit) begin
                if (is_st) meta[c_idx].dirty <= 1'b1;
                if (op == OP_LDX) meta[c_idx].excl <= 1'b1;
            end
        end
    end

    // Tag and data storage
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            line_tag[free_idx]  <= op_addr;
            line_data[free_idx] <= is_st ? op_wdata : mem_rdata;
        end else if (do_hit && is_st) begin
            line_data[c_idx] <= op_wdata;
        end
    end

    // Registered responses
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_ok        <= 1'b0;
            rsp_data      <= '0;
            snp_rsp_valid <= 1'b0;
            snp_nack      <= 1'b0;
        end else begin
            rsp_valid     <= op_go;
            rsp_ok        <= nxt_ok;
            rsp_data      <= nxt_data;
            snp_rsp_valid <= snp_valid;
            snp_nack      <= snp_valid && s_conf;
        end
    end

    a_r2_rsp_follows_op:  assert property (@(posedge clk) disable iff (rst) (op_valid && op_ready) |=> rsp_valid);
    a_r2_no_stray_rsp:    assert property (@(posedge clk) disable iff (rst) !(op_valid && op_ready) |=> !rsp_valid);
    a_r5_wb_while_busy:   assert property (@(posedge clk) disable iff (rst) wb_valid |-> !op_ready);
    a_r5_commit_drains:   assert property (@(posedge clk) disable iff (rst) commit_ok |=> !op_ready);
    a_r7_validate_stable: assert property (@(posedge clk) disable iff (rst)
        (op_go && op == OP_VALIDATE) |=> ($stable(flag_valid) && $stable(flag_active)));
    a_r8_snoop_reply:     assert property (@(posedge clk) disable iff (rst) snp_valid |=> snp_rsp_valid);
    a_r8_nack_qualified:  assert property (@(posedge clk) disable iff (rst) snp_nack |-> snp_rsp_valid);

endmodule

// File: tb/txn_line_buffer_tb.sv
`timescale 1ns/1ps
module txn_line_buffer_tb;
    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam logic [15:0] POISON = 16'hAAAA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [DATA_W-1:0] op_wdata = '0;
    logic op_ready, rsp_valid, rsp_ok;
    logic [DATA_W-1:0] rsp_data;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic mem_nack = 1'b0;
    logic snp_valid = 1'b0, snp_excl = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic snp_rsp_valid, snp_nack, wb_valid, overflow;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    logic [DATA_W-1:0] mem_img [256];
    logic [DATA_W-1:0] exp_wb  [256];
    logic              exp_has [256];
    int n_chk = 0, n_err = 0;
    logic done = 1'b0;
    logic r_ok;
    logic [DATA_W-1:0] r_data;
    logic s_nack;

    always #10 clk = ~clk;
    assign mem_rdata = mem_img[mem_raddr];

    txn_line_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

    function automatic logic [15:0] memval(input int a);
        return 16'(a * 37 + 257);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] code, input int addr, input logic [15:0] wd);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = ADDR_W'(addr); op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        r_ok = rsp_ok; r_data = rsp_data;
    endtask

    task automatic snoop(input int addr, input logic excl);
        @(negedge clk);
        snp_valid = 1'b1; snp_excl = excl; snp_addr = ADDR_W'(addr);
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R8 snp_rsp_valid", 32'(snp_rsp_valid), 32'd1);
        s_nack = snp_nack;
    endtask

    task automatic commit_drain(input int n_exp);
        int seen = 0;
        op(3'd3, 0, '0);
        chk("R5 commit ok", 32'(r_ok), 32'd1);
        for (int c = 0; c < ENTRIES; c++) begin
            chk("R5 busy during drain", 32'(op_ready), 32'd0);
            if (wb_valid) begin
                seen++;
                chk("R5 wb line expected", 32'(exp_has[wb_addr]), 32'd1);
                chk("R5 wb data", 32'(wb_data), 32'(exp_wb[wb_addr]));
                exp_has[wb_addr] = 1'b0;
                mem_img[wb_addr] = wb_data;
            end
            @(negedge clk);
        end
        chk("R5 ready after drain", 32'(op_ready), 32'd1);
        chk("R5 wb count", 32'(seen), 32'(n_exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_img[i] = memval(i);
            exp_has[i] = 1'b0;
            exp_wb[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 op_ready", 32'(op_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 snp_rsp_valid", 32'(snp_rsp_valid), 32'd0);
        chk("R1 wb_valid", 32'(wb_valid), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
        op(3'd5, 0, '0);
        chk("R1 validate after reset", 32'(r_ok), 32'd0);

        // R3 fill sweep across every slot
        for (int a = 10; a < 10 + ENTRIES; a++) begin
            op(3'd0, a, '0);
            chk("R3 fill ok", 32'(r_ok), 32'd1);
            chk("R3 fill data", 32'(r_data), 32'(memval(a)));
        end
        mem_img[10] = 16'h1234;
        op(3'd0, 10, '0);
        chk("R3 buffered copy kept", 32'(r_data), 32'(memval(10)));
        // R10 overflow
        op(3'd0, 10 + ENTRIES, '0);
        chk("R10 overflow ok", 32'(r_ok), 32'd0);
        chk("R10 overflow data", 32'(r_data), 32'(POISON));
        chk("R10 overflow flag", 32'(overflow), 32'd1);
        op(3'd5, 0, '0);
        chk("R10 valid cleared", 32'(r_ok), 32'd0);
        op(3'd0, 11, '0);
        chk("R12 hit returns poison", 32'(r_data), 32'(POISON));
        chk("R12 hit not ok", 32'(r_ok), 32'd0);
        chk("R10 overflow held", 32'(overflow), 32'd1);
        op(3'd4, 0, '0);
        chk("R6 abort ok", 32'(r_ok), 32'd1);
        chk("R6 overflow cleared", 32'(overflow), 32'd0);
        op(3'd5, 0, '0);
        chk("R6 validate after abort", 32'(r_ok), 32'd0);
        mem_img[10] = memval(10);

        // R8 snoop sweep: shared, exclusive, written, miss
        op(3'd0, 20, '0);
        op(3'd1, 21, '0);
        op(3'd2, 22, 16'h5555);
        exp_wb[22] = 16'h5555; exp_has[22] = 1'b1;
        for (int a = 0; a < 4; a++) begin
            for (int e = 0; e < 2; e++) begin
                snoop(20 + a, e[0]);
                chk("R8 nack", 32'(s_nack), 32'((a < 3) && (e == 1 || a != 0)));
            end
        end
        op(3'd5, 0, '0);
        chk("R9 valid after refusals", 32'(r_ok), 32'd1);
        op(3'd0, 22, '0);
        chk("R4 read own write", 32'(r_data), 32'h5555);
        chk("R4 no early write-back", 32'(wb_valid), 32'd0);
        op(3'd2, 20, 16'h7777);
        exp_wb[20] = 16'h7777; exp_has[20] = 1'b1;
        snoop(20, 1'b0);
        chk("R8 written line refuses read", 32'(s_nack), 32'd1);
        commit_drain(2);
        op(3'd5, 0, '0);
        chk("R5 validate after commit", 32'(r_ok), 32'd0);
        op(3'd0, 22, '0);
        chk("R5 committed value visible", 32'(r_data), 32'h5555);
        op(3'd4, 0, '0);

        // R6 abort discards written data
        op(3'd2, 30, 16'h1111);
        op(3'd4, 0, '0);
        chk("R6 no write-back on abort", 32'(wb_valid), 32'd0);
        op(3'd0, 30, '0);
        chk("R6 memory unchanged", 32'(r_data), 32'(memval(30)));
        op(3'd4, 0, '0);

        // R11 refused fill, R12 ignored stores, R6 failed commit
        mem_nack = 1'b1;
        op(3'd0, 31, '0);
        mem_nack = 1'b0;
        chk("R11 refused fill ok", 32'(r_ok), 32'd0);
        chk("R11 refused fill data", 32'(r_data), 32'(POISON));
        snoop(31, 1'b1);
        chk("R11 no line allocated", 32'(s_nack), 32'd0);
        op(3'd2, 32, 16'h2222);
        chk("R12 store ignored ok", 32'(r_ok), 32'd0);
        snoop(32, 1'b0);
        chk("R12 store did not allocate", 32'(s_nack), 32'd0);
        op(3'd3, 0, '0);
        chk("R6 failed commit", 32'(r_ok), 32'd0);
        chk("R6 no drain after failed commit", 32'(op_ready), 32'd1);
        chk("R6 no wb after failed commit", 32'(wb_valid), 32'd0);

        // R12 store to a held shared line is ignored once invalid
        op(3'd0, 50, '0);
        mem_nack = 1'b1;
        op(3'd0, 51, '0);
        mem_nack = 1'b0;
        op(3'd2, 50, 16'h3333);
        snoop(50, 1'b0);
        chk("R12 held line not dirtied", 32'(s_nack), 32'd0);
        op(3'd4, 0, '0);

        // R7 validate does not change state
        op(3'd0, 40, '0);
        op(3'd5, 0, '0);
        chk("R7 validate first", 32'(r_ok), 32'd1);
        op(3'd5, 0, '0);
        chk("R7 validate repeat", 32'(r_ok), 32'd1);
        op(3'd0, 40, '0);
        chk("R7 line still held", 32'(r_data), 32'(memval(40)));
        op(3'd4, 0, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule